// File: doc/BRIEF.md
# Debug memory access sequencer

This block sits between a host-side command source and a debug link that carries single register transactions. It turns four kinds of memory requests into ordered access-port and debug-port transactions. A single write, a single read, a byte-streamed burst write and a fixed-address sampling loop are each translated into the right sequence. Each transaction waits for its response before the next one issues, and any failed response ends the request. The link itself, including wire timing and bring-up, is modelled as a request/response handshake on `txn*` and `rsp*`.

For reads, the block handles the one-deep pipeline of the memory access port. An access-port data read returns the result of the previous read, so a single read ends with a debug-port read of the read buffer. Sampling discards its first response. For bursts, the block expects the port's address counter to increment by one word per data access. Because that counter wraps on `WRAP_BYTES` boundaries, the block writes the address again whenever a word lands on such a boundary. Burst bytes arrive on a ready/valid stream and are packed little-endian. A word goes out as soon as its fourth byte has arrived.

Top module: `dbg_mem_seq`

## Requirements
- R1: A write request (op 1) issues an access-port write of the address to register index 1, then an access-port write of the request data to register index 3, then pulses done with error 0 and index 0.
- R2: A read request (op 0) issues an access-port write of the address to index 1, an access-port read of index 3 and a debug-port read of index 3. It presents the last response's data on `outData` with a one-cycle `outValid`, then pulses done with error 0.
- R3: A burst (op 2, `reqCount` in bytes) first writes `CSW_INCR` to access-port index 0. Every four accepted stream bytes form one word, with byte k at bits 8k+7:8k, and each word issues as an access-port write to index 3. On success, done reports index = number of words written.
- R4: During a burst, the address write (index 1) is issued before the first word and before each word whose address is a multiple of `WRAP_BYTES`, and before no other word.
- R5: A burst with an address not on a 4-byte boundary, or a length that is zero or not a multiple of 4, or a sample request with count 0, is rejected. Done pulses on the cycle after acceptance with error 1 and index 0. No transaction issues, and no stream byte is accepted.
- R6: A sample request (op 3, `reqCount` = samples) writes `CSW_FIXED` to index 0, writes the address to index 1, then issues count+1 access-port reads of index 3. The first response is dropped and each later response appears on `outData`. Done reports index = samples delivered.
- R7: A response with `rspOk` low stops the request at once. Done pulses with error 1 and index = the burst word or the number of samples delivered when it failed. The next request runs normally.
- R8: Only one transaction is outstanding: after a `txnValid`/`txnReady` handshake, `txnValid` stays low until the response arrives. While waiting for `txnReady`, all transaction fields hold steady.
- R9: `reqReady` is high only when no request is in progress, `byteReady` only while a burst is collecting a word, and done is a single-cycle pulse followed by `reqReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqOp | input | 2 | 0 read, 1 write, 2 burst write, 3 sample |
| reqAddr | input | 32 | Target memory address |
| reqWdata | input | 32 | Value for a single write |
| reqCount | input | CNT_W | Burst length in bytes or number of samples |
| byteValid | input | 1 | Burst stream byte offered |
| byteReady | output | 1 | Burst stream byte accepted |
| byteData | input | 8 | Burst stream byte |
| txnValid | output | 1 | Link transaction offered |
| txnReady | input | 1 | Link transaction accepted |
| txnAp | output | 1 | 1 access port, 0 debug port |
| txnRead | output | 1 | 1 read, 0 write |
| txnReg | output | 2 | Register index (address bits 3:2) |
| txnWdata | output | 32 | Write value |
| rspValid | input | 1 | Link response present |
| rspOk | input | 1 | Response acknowledged without fault |
| rspRdata | input | 32 | Read data of the response |
| outValid | output | 1 | Read or sample result valid (one cycle) |
| outData | output | 32 | Read or sample result |
| doneValid | output | 1 | Request finished (one cycle) |
| doneErr | output | 1 | Request rejected or failed |
| doneIdx | output | CNT_W | Words or samples completed |

## Verification
The bench aims at the burst crossing of a wrap boundary at 0x2000 and checks that only the address write sits exactly there. A design that compared the wrong address bits would lose or add that address write. Posted reads are checked by tying each returned value to the read that produced it: a block that returned the access-port response directly, or kept the first sample, would shift every value by one. Rejected bursts are offered stream bytes to show none are consumed. Failures injected at a mid-burst word and a mid-sampling read check that the reported index names the failing position, not one past it, and that a following write still completes.

// File: rtl/dms_pkg.sv
package dms_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_BURST  = 2'd2,
    OP_SAMPLE = 2'd3
  } dmsOp_e;

  typedef enum logic [1:0] {
    WS_CSW_INCR  = 2'd0,
    WS_CSW_FIXED = 2'd1,
    WS_ADDR      = 2'd2,
    WS_WORD      = 2'd3
  } dmsWsel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     takeByte;
    logic     advWord;
    logic     advSample;
    logic     clrFirst;
    logic     emit;
    dmsWsel_e wsel;
  } dmsStrobe_t;

  localparam logic [1:0] REG_CFG  = 2'd0;
  localparam logic [1:0] REG_ADDR = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd3;
endpackage

// File: rtl/dms_datapath.sv
module dms_datapath
  import dms_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          WRAP_BYTES = 4096,
  parameter logic [31:0] CSW_INCR   = 32'h2300_0012,
  parameter logic [31:0] CSW_FIXED  = 32'h2300_0002
) (
  input  logic             clk,
  input  logic             rstN,
  input  dmsStrobe_t       st,
  input  logic             isBurst,
  input  logic [31:0]      reqAddr,
  input  logic [31:0]      reqWdata,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [7:0]       byteData,
  input  logic [31:0]      rspRdata,
  output logic             wordFull,
  output logic             lastOne,
  output logic             atWrap,
  output logic             isFirst,
  output logic [CNT_W-1:0] idx,
  output logic [31:0]      txnWdata,
  output logic             outValid,
  output logic [31:0]      outData
);
  localparam int WRAP_LG = $clog2(WRAP_BYTES);
  localparam int LANES   = 4;

  logic [31:0]      curAddr;
  logic [31:0]      word, wordNext;
  logic [CNT_W-1:0] remain;
  logic [2:0]       byteCnt;

  always_comb begin
    wordNext = word;
    if (st.load) wordNext = reqWdata;
    else if (st.takeByte) begin
      for (int b = 0; b < LANES; b++)
        if (byteCnt[1:0] == b[1:0]) wordNext[b*8 +: 8] = byteData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      word     <= '0;
      remain   <= '0;
      byteCnt  <= '0;
      idx      <= '0;
      isFirst  <= 1'b0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      word     <= wordNext;
      outValid <= st.emit;
      if (st.emit) outData <= rspRdata;
      if (st.load) begin
        curAddr <= reqAddr;
        remain  <= isBurst ? (reqCount >> 2) : reqCount;
        byteCnt <= '0;
        idx     <= '0;
        isFirst <= 1'b1;
      end else begin
        if (st.takeByte) byteCnt <= byteCnt + 3'd1;
        if (st.advWord) begin
          curAddr <= curAddr + 32'd4;
          byteCnt <= '0;
        end
        if (st.advWord || st.advSample) begin
          remain <= remain - 1'b1;
          idx    <= idx + 1'b1;
        end
        if (st.advWord || st.clrFirst) isFirst <= 1'b0;
      end
    end
  end

  assign wordFull = byteCnt[2];
  assign lastOne  = (remain == {{(CNT_W-1){1'b0}}, 1'b1});
  assign atWrap   = (curAddr[WRAP_LG-1:0] == '0);

  always_comb begin
    unique case (st.wsel)
      WS_CSW_INCR:  txnWdata = CSW_INCR;
      WS_CSW_FIXED: txnWdata = CSW_FIXED;
      WS_ADDR:      txnWdata = curAddr;
      default:      txnWdata = word;
    endcase
  end
endmodule

// File: rtl/dms_control.sv
module dms_control
  import dms_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [1:0]       reqAddrLo,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             byteValid,
  input  logic             txnReady,
  input  logic             rspValid,
  input  logic             rspOk,
  input  logic             wordFull,
  input  logic             lastOne,
  input  logic             atWrap,
  input  logic             isFirst,
  output logic             reqReady,
  output logic             byteReady,
  output logic             txnValid,
  output logic             txnAp,
  output logic             txnRead,
  output logic [1:0]       txnReg,
  output logic             isBurst,
  output logic             doneValid,
  output logic             doneErr,
  output dmsStrobe_t       st
);
  typedef enum logic [2:0] {
    S_IDLE, S_CFG, S_ADDR, S_COLLECT, S_DATA, S_RDBUF, S_FIN
  } state_e;

  state_e state, stateNext;
  dmsOp_e opReg, opNext, reqOpE;
  logic   waitRsp, waitNext, errReg, errNext;
  logic   inTxn, rspDone, reqBad;

  assign reqOpE = dmsOp_e'(reqOp);
  assign reqBad = (reqOpE == OP_BURST &&
                   (reqAddrLo != 2'd0 || reqCount[1:0] != 2'd0 || reqCount == '0)) ||
                  (reqOpE == OP_SAMPLE && reqCount == '0);

  assign inTxn   = (state == S_CFG) || (state == S_ADDR) || (state == S_DATA) || (state == S_RDBUF);
  assign txnValid = inTxn && !waitRsp;
  assign rspDone  = inTxn && waitRsp && rspValid;
  assign reqReady = (state == S_IDLE);
  assign byteReady = (state == S_COLLECT) && !wordFull;
  assign doneValid = (state == S_FIN);
  assign doneErr   = errReg;
  assign isBurst   = (reqOpE == OP_BURST);

  always_comb begin
    st        = '0;
    st.wsel   = WS_ADDR;
    stateNext = state;
    opNext    = opReg;
    waitNext  = waitRsp;
    errNext   = errReg;
    txnAp     = 1'b1;
    txnRead   = 1'b0;
    txnReg    = REG_DATA;

    unique case (state)
      S_CFG:   begin txnReg = REG_CFG;
                 st.wsel = (opReg == OP_SAMPLE) ? WS_CSW_FIXED : WS_CSW_INCR; end
      S_ADDR:  txnReg = REG_ADDR;
      S_DATA:  begin txnRead = (opReg == OP_READ) || (opReg == OP_SAMPLE); st.wsel = WS_WORD; end
      S_RDBUF: begin txnAp = 1'b0; txnRead = 1'b1; end
      default: ;
    endcase

    if (txnValid && txnReady) waitNext = 1'b1;

    if (rspDone) begin
      waitNext = 1'b0;
      if (!rspOk) begin
        errNext   = 1'b1;
        stateNext = S_FIN;
      end else begin
        unique case (state)
          S_CFG:  stateNext = (opReg == OP_SAMPLE) ? S_ADDR : S_COLLECT;
          S_ADDR: stateNext = S_DATA;
          S_RDBUF: begin st.emit = 1'b1; stateNext = S_FIN; end
          default: begin
            unique case (opReg)
              OP_WRITE: stateNext = S_FIN;
              OP_READ:  stateNext = S_RDBUF;
              OP_BURST: begin
                st.advWord = 1'b1;
                stateNext  = lastOne ? S_FIN : S_COLLECT;
              end
              default: begin
                if (isFirst) st.clrFirst = 1'b1;
                else begin
                  st.emit      = 1'b1;
                  st.advSample = 1'b1;
                  if (lastOne) stateNext = S_FIN;
                end
              end
            endcase
          end
        endcase
      end
    end

    unique case (state)
      S_IDLE: if (reqValid) begin
        st.load = 1'b1;
        opNext  = reqOpE;
        errNext = reqBad;
        if (reqBad) stateNext = S_FIN;
        else if (reqOpE == OP_READ || reqOpE == OP_WRITE) stateNext = S_ADDR;
        else stateNext = S_CFG;
      end
      S_COLLECT: begin
        st.takeByte = byteValid && !wordFull;
        if (wordFull) stateNext = (isFirst || atWrap) ? S_ADDR : S_DATA;
      end
      S_FIN: stateNext = S_IDLE;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opReg   <= OP_READ;
      waitRsp <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      state   <= stateNext;
      opReg   <= opNext;
      waitRsp <= waitNext;
      errReg  <= errNext;
    end
  end
endmodule

// File: rtl/dbg_mem_seq.sv
module dbg_mem_seq
  import dms_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          WRAP_BYTES = 4096,
  parameter logic [31:0] CSW_INCR   = 32'h2300_0012,
  parameter logic [31:0] CSW_FIXED  = 32'h2300_0002
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [31:0]      reqAddr,
  input  logic [31:0]      reqWdata,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             byteValid,
  output logic             byteReady,
  input  logic [7:0]       byteData,
  output logic             txnValid,
  input  logic             txnReady,
  output logic             txnAp,
  output logic             txnRead,
  output logic [1:0]       txnReg,
  output logic [31:0]      txnWdata,
  input  logic             rspValid,
  input  logic             rspOk,
  input  logic [31:0]      rspRdata,
  output logic             outValid,
  output logic [31:0]      outData,
  output logic             doneValid,
  output logic             doneErr,
  output logic [CNT_W-1:0] doneIdx
);
  dmsStrobe_t st;
  logic wordFull, lastOne, atWrap, isFirst, isBurst;

  dms_control #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddrLo(reqAddr[1:0]), .reqCount(reqCount), .byteValid(byteValid),
    .txnReady(txnReady), .rspValid(rspValid), .rspOk(rspOk),
    .wordFull(wordFull), .lastOne(lastOne), .atWrap(atWrap), .isFirst(isFirst),
    .reqReady(reqReady), .byteReady(byteReady), .txnValid(txnValid),
    .txnAp(txnAp), .txnRead(txnRead), .txnReg(txnReg), .isBurst(isBurst),
    .doneValid(doneValid), .doneErr(doneErr), .st(st)
  );

  dms_datapath #(.CNT_W(CNT_W), .WRAP_BYTES(WRAP_BYTES),
                 .CSW_INCR(CSW_INCR), .CSW_FIXED(CSW_FIXED)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .isBurst(isBurst), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqCount(reqCount), .byteData(byteData),
    .rspRdata(rspRdata), .wordFull(wordFull), .lastOne(lastOne),
    .atWrap(atWrap), .isFirst(isFirst), .idx(doneIdx), .txnWdata(txnWdata),
    .outValid(outValid), .outData(outData)
  );
endmodule

// File: rtl/dms_checker.sv
module dms_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [1:0]       reqOp,
  input logic [31:0]      reqAddr,
  input logic [CNT_W-1:0] reqCount,
  input logic             byteReady,
  input logic             txnValid,
  input logic             txnReady,
  input logic             txnAp,
  input logic             txnRead,
  input logic [1:0]       txnReg,
  input logic [31:0]      txnWdata,
  input logic             outValid,
  input logic             doneValid,
  input logic             doneErr
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    txnValid && !txnReady |=> txnValid && $stable(txnAp) && $stable(txnRead)
                              && $stable(txnReg) && $stable(txnWdata));

  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rstN)
    txnValid && txnReady |=> !txnValid);

  p_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  p_byte_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> !reqReady && !txnValid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid && reqReady);

  p_out_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  p_reject_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqOp == 2'd2 && reqAddr[1:0] != 2'd0
    |=> doneValid && doneErr);

  p_reject_cnt_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqOp == 2'd3 && reqCount == '0
    |=> doneValid && doneErr);
endmodule

bind dbg_mem_seq dms_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqOp(reqOp), .reqAddr(reqAddr), .reqCount(reqCount), .byteReady(byteReady),
  .txnValid(txnValid), .txnReady(txnReady), .txnAp(txnAp), .txnRead(txnRead),
  .txnReg(txnReg), .txnWdata(txnWdata), .outValid(outValid),
  .doneValid(doneValid), .doneErr(doneErr)
);

// File: tb/test_dbg_mem_seq.sv
`timescale 1ns/1ps
module test_dbg_mem_seq;
  localparam int          CNT_W = 16;
  localparam logic [31:0] CSW_INCR  = 32'h2300_0012;
  localparam logic [31:0] CSW_FIXED = 32'h2300_0002;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [1:0] reqOp = '0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [CNT_W-1:0] reqCount = '0;
  logic byteValid = 1'b0, byteReady;
  logic [7:0] byteData = '0;
  logic txnValid, txnReady, txnAp, txnRead;
  logic [1:0] txnReg;
  logic [31:0] txnWdata;
  logic rspValid, rspOk;
  logic [31:0] rspRdata;
  logic outValid, doneValid, doneErr;
  logic [31:0] outData;
  logic [CNT_W-1:0] doneIdx;

  always #10 clk = ~clk;

  dbg_mem_seq #(.CNT_W(CNT_W), .CSW_INCR(CSW_INCR), .CSW_FIXED(CSW_FIXED)) i_dbg_mem_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqCount(reqCount),
    .byteValid(byteValid), .byteReady(byteReady), .byteData(byteData),
    .txnValid(txnValid), .txnReady(txnReady), .txnAp(txnAp), .txnRead(txnRead),
    .txnReg(txnReg), .txnWdata(txnWdata), .rspValid(rspValid), .rspOk(rspOk),
    .rspRdata(rspRdata), .outValid(outValid), .outData(outData),
    .doneValid(doneValid), .doneErr(doneErr), .doneIdx(doneIdx)
  );

  int tests = 0, fails = 0;
  string curReq = "R1";
  logic [35:0] expTxn[$];
  logic [31:0] expOut[$];
  logic [16:0] expDone[$];
  logic [7:0]  bq[$];

  // link model state
  logic [31:0] tar = '0, apBuf = '0;
  int apCnt = 0, txnNum = 0, failAt = -1;
  bit stallOn = 0, stalled = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] tx(input bit ap, input bit rd, input logic [1:0] rg, input logic [31:0] wd);
    return {ap, rd, rg, rd ? 32'h0 : wd};
  endfunction

  function automatic logic [31:0] mkVal(input logic [31:0] a, input int n);
    return {a[15:0], n[15:0]} ^ 32'h5a00_0000;
  endfunction

  // link target + transaction scoreboard
  initial begin
    txnReady = 1'b1; rspValid = 1'b0; rspOk = 1'b1; rspRdata = '0;
    forever begin
      @(negedge clk);
      rspValid = 1'b0;
      if (txnValid) begin
        if (stallOn && !stalled) begin
          txnReady = 1'b0; stalled = 1;
        end else begin
          logic [35:0] got, exp;
          logic [31:0] d;
          bit ok;
          txnReady = 1'b1; stalled = 0;
          got = tx(txnAp, txnRead, txnReg, txnWdata);
          if (expTxn.size() == 0) check(0, curReq, {28'h0, got}, 64'h0);
          else begin
            exp = expTxn.pop_front();
            check(got === exp, curReq, {28'h0, got}, {28'h0, exp});
          end
          ok = (txnNum != failAt);
          txnNum++;
          d = '0;
          if (txnAp && !txnRead && txnReg == 2'd1) tar = txnWdata;
          if (txnAp && txnRead && txnReg == 2'd3) begin
            d = apBuf; apBuf = mkVal(tar, apCnt); apCnt++;
          end
          if (!txnAp && txnRead && txnReg == 2'd3) d = apBuf;
          @(negedge clk);
          rspValid = 1'b1; rspOk = ok; rspRdata = d;
        end
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && outValid) begin
        if (expOut.size() == 0) check(0, curReq, {32'h0, outData}, 64'h0);
        else begin
          logic [31:0] e;
          e = expOut.pop_front();
          check(outData === e, curReq, {32'h0, outData}, {32'h0, e});
        end
      end
      if (rstN && doneValid) begin
        if (expDone.size() == 0) check(0, curReq, {47'h0, doneErr, doneIdx}, 64'h0);
        else begin
          logic [16:0] e;
          e = expDone.pop_front();
          check({doneErr, doneIdx} === e, curReq, {47'h0, doneErr, doneIdx}, {47'h0, e});
        end
      end
    end
  end

  task automatic sendReq(input logic [1:0] op, input logic [31:0] a, input logic [31:0] wd, input int cnt);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqWdata = wd; reqCount = cnt[CNT_W-1:0];
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone();
    while (!doneValid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic feedBytes(input int gap);
    @(negedge clk);
    foreach (bq[i]) begin
      byteData = bq[i]; byteValid = 1'b1;
      while (!byteReady) @(negedge clk);
      @(negedge clk);
      if (gap > 0) begin
        byteValid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    byteValid = 1'b0;
  endtask

  task automatic expBurst(input logic [31:0] base, input int nb, input logic [7:0] b0);
    bq.delete();
    for (int i = 0; i < nb; i++) bq.push_back(b0 + i[7:0]);
    expTxn.push_back(tx(1, 0, 2'd0, CSW_INCR));
    for (int w = 0; w < nb / 4; w++) begin
      logic [31:0] a;
      a = base + 32'(4 * w);
      if (w == 0 || a[11:0] == 12'h0) expTxn.push_back(tx(1, 0, 2'd1, a));
      expTxn.push_back(tx(1, 0, 2'd3, {bq[4*w+3], bq[4*w+2], bq[4*w+1], bq[4*w]}));
    end
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 64'h0, 64'h1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R9";
    check(reqReady === 1'b1, "R9 reset", {63'h0, reqReady}, 64'h1);
    check(txnValid === 1'b0, "R8 reset", {63'h0, txnValid}, 64'h0);
    check(byteReady === 1'b0, "R9 reset", {63'h0, byteReady}, 64'h0);
    check({doneValid, outValid} === 2'b00, "R9 reset", {62'h0, doneValid, outValid}, 64'h0);

    // single write
    curReq = "R1";
    expTxn.push_back(tx(1, 0, 2'd1, 32'h2000_0010));
    expTxn.push_back(tx(1, 0, 2'd3, 32'hDEAD_BEEF));
    expDone.push_back({1'b0, 16'd0});
    sendReq(2'd1, 32'h2000_0010, 32'hDEAD_BEEF, 0);
    waitDone();

    // single read with link stalls
    curReq = "R2"; stallOn = 1;
    expTxn.push_back(tx(1, 0, 2'd1, 32'h2000_0040));
    expTxn.push_back(tx(1, 1, 2'd3, 32'h0));
    expTxn.push_back(tx(0, 1, 2'd3, 32'h0));
    expOut.push_back(mkVal(32'h2000_0040, apCnt));
    expDone.push_back({1'b0, 16'd0});
    sendReq(2'd0, 32'h2000_0040, 32'h0, 0);
    waitDone();

    // burst across wrap boundary 0x2000 (R4)
    curReq = "R4";
    expBurst(32'h0000_1FF8, 16, 8'h10);
    expDone.push_back({1'b0, 16'd4});
    fork
      sendReq(2'd2, 32'h0000_1FF8, 32'h0, 16);
      feedBytes(0);
    join
    waitDone();
    stallOn = 0;

    // burst without wrap, gapped stream (R3)
    curReq = "R3";
    expBurst(32'h0000_0100, 8, 8'hA0);
    expDone.push_back({1'b0, 16'd2});
    fork
      sendReq(2'd2, 32'h0000_0100, 32'h0, 8);
      feedBytes(3);
    join
    waitDone();

    // sampling
    curReq = "R6";
    expTxn.push_back(tx(1, 0, 2'd0, CSW_FIXED));
    expTxn.push_back(tx(1, 0, 2'd1, 32'hE000_1004));
    for (int k = 0; k < 4; k++) expTxn.push_back(tx(1, 1, 2'd3, 32'h0));
    for (int k = 0; k < 3; k++) expOut.push_back(mkVal(32'hE000_1004, apCnt + k));
    expDone.push_back({1'b0, 16'd3});
    sendReq(2'd3, 32'hE000_1004, 32'h0, 3);
    waitDone();

    // rejects: misaligned burst, bad length, zero samples; bytes offered meanwhile
    curReq = "R5";
    byteValid = 1'b1; byteData = 8'h55;
    expDone.push_back({1'b1, 16'd0});
    sendReq(2'd2, 32'h0000_0102, 32'h0, 8);
    waitDone();
    check(byteReady === 1'b0, "R5 byte ignored", {63'h0, byteReady}, 64'h0);
    expDone.push_back({1'b1, 16'd0});
    sendReq(2'd2, 32'h0000_0200, 32'h0, 6);
    waitDone();
    check(byteReady === 1'b0, "R5 byte ignored", {63'h0, byteReady}, 64'h0);
    expDone.push_back({1'b1, 16'd0});
    sendReq(2'd3, 32'h0000_0300, 32'h0, 0);
    waitDone();
    byteValid = 1'b0;
    check(expTxn.size() == 0, "R5 no transactions", 64'(expTxn.size()), 64'h0);

    // burst failing on word 2
    curReq = "R7";
    expBurst(32'h0000_0300, 12, 8'h40);
    failAt = txnNum + 4;
    expDone.push_back({1'b1, 16'd2});
    fork
      sendReq(2'd2, 32'h0000_0300, 32'h0, 16);
      feedBytes(0);
    join
    waitDone();

    // sampling failing on second kept read
    expTxn.push_back(tx(1, 0, 2'd0, CSW_FIXED));
    expTxn.push_back(tx(1, 0, 2'd1, 32'h0000_0400));
    for (int k = 0; k < 3; k++) expTxn.push_back(tx(1, 1, 2'd3, 32'h0));
    expOut.push_back(mkVal(32'h0000_0400, apCnt));
    failAt = txnNum + 4;
    expDone.push_back({1'b1, 16'd1});
    sendReq(2'd3, 32'h0000_0400, 32'h0, 4);
    waitDone();

    // recovery write after error
    expTxn.push_back(tx(1, 0, 2'd1, 32'h0000_0500));
    expTxn.push_back(tx(1, 0, 2'd3, 32'h1234_5678));
    expDone.push_back({1'b0, 16'd0});
    sendReq(2'd1, 32'h0000_0500, 32'h1234_5678, 0);
    waitDone();

    repeat (4) @(negedge clk);
    check(expTxn.size() == 0, "R8 pending txns", 64'(expTxn.size()), 64'h0);
    check(expOut.size() == 0, "R2 pending outs", 64'(expOut.size()), 64'h0);
    check(expDone.size() == 0, "R9 pending dones", 64'(expDone.size()), 64'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule